// File: doc/BRIEF.md
# Bus access failure supervisor

This block sits beside the system-bus master port of a communication controller and guards every access the controller makes. A watchdog times each outstanding access against a programmable limit, and the bus can also report an access to an illegal address. Either failure sets its own sticky error flag, which software clears by a write-1-to-clear strobe.

A policy input selects what happens after a failure. With the policy set, the controller is frozen on the next clock edge and stays frozen until an unfreeze input is asserted. With the policy clear, the controller keeps running in a degraded state until the next communication cycle starts. In that state it issues no bus accesses. A frame being sent in the slot where the failure happened is finished with zeros in place of its remaining bits. A frame being received in that slot is aborted. From the next slot on, frames are blocked, except that an assigned key slot still sends a sync or startup null frame.

Top module: `bus_fail_supervisor`

## Requirements
- R1: An access starts on the first clock edge at which `acc_req_i` is high, the watchdog is idle and `bus_inhibit_o` is low. With `tmo_cfg_i` = T >= 2, `err_tmo_o` rises after the edge that lies 2T+2 edges past the start edge, unless `acc_done_i` was high at or before that edge. A completion sampled on that last edge counts as success, and the watchdog then stays idle.
- R2: With T equal to 0 or 1, every access sets `err_tmo_o` on the edge after its start, whether or not `acc_done_i` is high.
- R3: A one-cycle `ill_addr_i` pulse sets `err_ill_o` on the next edge and leaves `err_tmo_o` unchanged.
- R4: Both flags stay set until their clear strobe (`clr_tmo_i`, `clr_ill_i`) is high at an edge. A clear in the same cycle as a new failure leaves the flag set.
- R5: With `freeze_pol_i` = 1, a failure raises `freeze_o` and `bus_inhibit_o` on the next edge. Both hold, even across `cycle_start_i`, until `unfreeze_i` is high at an edge.
- R6: With `freeze_pol_i` = 0, a failure raises `bus_inhibit_o` with `freeze_o` low. While inhibited, a request starts no watchdog, so no timeout can be flagged.
- R7: In the slot in which a continue-mode failure occurs, `tx_zero_o` follows `tx_active_i` and `rx_abort_o` follows `rx_active_i`.
- R8: After the next `slot_start_i` in the degraded state, `tx_zero_o` and `rx_abort_o` are low. `frame_block_o` is high when `key_slot_i` is low, and `key_null_o` is high when `key_slot_i` is high.
- R9: A `cycle_start_i` while degraded returns the block to normal on the next edge, with every degraded output low.
- R10: A failure while degraded or frozen does not change the recovery state, whatever the policy bit is.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req_i | input | 1 | Controller issues a bus access |
| acc_done_i | input | 1 | Bus reports access finished |
| ill_addr_i | input | 1 | Bus reports an illegal-address access |
| tmo_cfg_i | input | TMO_W | Timeout setting T; limit is 2T+2 cycles |
| freeze_pol_i | input | 1 | 1: freeze on failure, 0: degrade until next cycle |
| clr_tmo_i | input | 1 | Write-1-to-clear for the timeout flag |
| clr_ill_i | input | 1 | Write-1-to-clear for the illegal-address flag |
| unfreeze_i | input | 1 | Releases freeze |
| cycle_start_i | input | 1 | Communication cycle begins |
| slot_start_i | input | 1 | Slot begins |
| key_slot_i | input | 1 | Current slot is the assigned key slot |
| tx_active_i | input | 1 | A frame is being transmitted |
| rx_active_i | input | 1 | A frame is being received |
| err_tmo_o | output | 1 | Sticky bus-timeout error flag |
| err_ill_o | output | 1 | Sticky illegal-address error flag |
| freeze_o | output | 1 | Controller frozen |
| bus_inhibit_o | output | 1 | No bus accesses allowed |
| tx_zero_o | output | 1 | Replace remaining transmit bits by zeros |
| rx_abort_o | output | 1 | Abort reception, no buffer write |
| frame_block_o | output | 1 | No frame sent or received in this slot |
| key_null_o | output | 1 | Key slot sends a null frame only |

## Verification
Failure flags, freeze and inhibit take effect one edge after the failing event. For a timeout, the failing event is the edge that lies 2T+2 edges after the start edge. The slot outputs follow `tx_active_i`, `rx_active_i` and `key_slot_i` combinationally once the state has changed. The bench counts the start edge and each later edge explicitly. It samples one clock before and one clock after the expiry edge, so that an off-by-one in either direction is reported. Drives and samples happen on the falling edge. The combinational key-slot response is checked a short delay after its input changes.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
    typedef enum logic [1:0] {
        SUP_RUN  = 2'd0,
        SUP_DEGR = 2'd1,
        SUP_FRZ  = 2'd2
    } sup_state_e;

    localparam int unsigned FLAG_TMO = 0;
    localparam int unsigned FLAG_ILL = 1;
    localparam int unsigned N_FLAGS  = 2;
endpackage

// File: rtl/bfs_watchdog.sv
module bfs_watchdog #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok_i,
    input  logic             done_i,
    input  logic             abort_i,
    input  logic [TMO_W-1:0] tmo_cfg_i,
    output logic             tmo_evt_o
);
    localparam int unsigned CNT_W = TMO_W + 2;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;
    logic [CNT_W-1:0] limit;
    logic             short_cfg;
    logic             expire;

    always_comb begin
        limit     = (CNT_W'(tmo_cfg_i) << 1) + CNT_W'(2);
        short_cfg = (tmo_cfg_i < TMO_W'(2));
        expire    = wd_q.busy && (short_cfg || ((wd_q.cnt >= limit) && !done_i));
        wd_d      = wd_q;
        if (wd_q.busy) begin
            if (expire || done_i || abort_i) begin
                wd_d.busy = 1'b0;
                wd_d.cnt  = '0;
            end else begin
                wd_d.cnt = wd_q.cnt + CNT_W'(1);
            end
        end else if (start_ok_i && !abort_i) begin
            wd_d.busy = 1'b1;
            wd_d.cnt  = CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign tmo_evt_o = expire;
endmodule

// File: rtl/bfs_err_flags.sv
module bfs_err_flags
    import bfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set_i,
    input  logic [N_FLAGS-1:0] clr_i,
    output logic [N_FLAGS-1:0] flags_o
);
    logic [N_FLAGS-1:0] flags_d, flags_q;

    always_comb begin
        for (int i = 0; i < N_FLAGS; i++) begin
            flags_d[i] = (flags_q[i] && !clr_i[i]) || set_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/bfs_policy.sv
module bfs_policy
    import bfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic pol_freeze_i,
    input  logic unfreeze_i,
    input  logic cycle_start_i,
    input  logic slot_start_i,
    input  logic key_slot_i,
    input  logic tx_active_i,
    input  logic rx_active_i,
    output logic freeze_o,
    output logic inhibit_o,
    output logic tx_zero_o,
    output logic rx_abort_o,
    output logic frame_block_o,
    output logic key_null_o
);
    typedef struct packed {
        sup_state_e st;
        logic       fail_slot;
    } pol_t;

    pol_t pol_d, pol_q;

    always_comb begin
        pol_d = pol_q;
        unique case (pol_q.st)
            SUP_RUN: begin
                if (fail_i) begin
                    pol_d.st        = pol_freeze_i ? SUP_FRZ : SUP_DEGR;
                    pol_d.fail_slot = !pol_freeze_i;
                end
            end
            SUP_DEGR: begin
                if (cycle_start_i) begin
                    pol_d.st        = SUP_RUN;
                    pol_d.fail_slot = 1'b0;
                end else if (slot_start_i) begin
                    pol_d.fail_slot = 1'b0;
                end
            end
            SUP_FRZ: begin
                if (unfreeze_i) pol_d.st = SUP_RUN;
            end
            default: pol_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= pol_d;
    end

    logic degr;
    assign degr          = (pol_q.st == SUP_DEGR);
    assign freeze_o      = (pol_q.st == SUP_FRZ);
    assign inhibit_o     = (pol_q.st != SUP_RUN);
    assign tx_zero_o     = degr && pol_q.fail_slot && tx_active_i;
    assign rx_abort_o    = degr && pol_q.fail_slot && rx_active_i;
    assign frame_block_o = degr && !pol_q.fail_slot && !key_slot_i;
    assign key_null_o    = degr && !pol_q.fail_slot && key_slot_i;
endmodule

// File: rtl/bus_fail_supervisor.sv
module bus_fail_supervisor
    import bfs_pkg::*;
#(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req_i,
    input  logic             acc_done_i,
    input  logic             ill_addr_i,
    input  logic [TMO_W-1:0] tmo_cfg_i,
    input  logic             freeze_pol_i,
    input  logic             clr_tmo_i,
    input  logic             clr_ill_i,
    input  logic             unfreeze_i,
    input  logic             cycle_start_i,
    input  logic             slot_start_i,
    input  logic             key_slot_i,
    input  logic             tx_active_i,
    input  logic             rx_active_i,
    output logic             err_tmo_o,
    output logic             err_ill_o,
    output logic             freeze_o,
    output logic             bus_inhibit_o,
    output logic             tx_zero_o,
    output logic             rx_abort_o,
    output logic             frame_block_o,
    output logic             key_null_o
);
    logic               tmo_evt;
    logic               inhibit;
    logic [N_FLAGS-1:0] flag_set, flag_clr, flags;

    bfs_watchdog #(.TMO_W(TMO_W)) i_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (acc_req_i && !inhibit),
        .done_i     (acc_done_i),
        .abort_i    (ill_addr_i),
        .tmo_cfg_i  (tmo_cfg_i),
        .tmo_evt_o  (tmo_evt)
    );

    always_comb begin
        flag_set           = '0;
        flag_clr           = '0;
        flag_set[FLAG_TMO] = tmo_evt;
        flag_set[FLAG_ILL] = ill_addr_i;
        flag_clr[FLAG_TMO] = clr_tmo_i;
        flag_clr[FLAG_ILL] = clr_ill_i;
    end

    bfs_err_flags i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    bfs_policy i_pol (
        .clk           (clk),
        .rst_n         (rst_n),
        .fail_i        (tmo_evt || ill_addr_i),
        .pol_freeze_i  (freeze_pol_i),
        .unfreeze_i    (unfreeze_i),
        .cycle_start_i (cycle_start_i),
        .slot_start_i  (slot_start_i),
        .key_slot_i    (key_slot_i),
        .tx_active_i   (tx_active_i),
        .rx_active_i   (rx_active_i),
        .freeze_o      (freeze_o),
        .inhibit_o     (inhibit),
        .tx_zero_o     (tx_zero_o),
        .rx_abort_o    (rx_abort_o),
        .frame_block_o (frame_block_o),
        .key_null_o    (key_null_o)
    );

    assign bus_inhibit_o = inhibit;
    assign err_tmo_o     = flags[FLAG_TMO];
    assign err_ill_o     = flags[FLAG_ILL];
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker (
    input logic clk,
    input logic rst_n,
    input logic ill_addr_i,
    input logic freeze_pol_i,
    input logic clr_tmo_i,
    input logic clr_ill_i,
    input logic unfreeze_i,
    input logic cycle_start_i,
    input logic key_slot_i,
    input logic err_tmo_o,
    input logic err_ill_o,
    input logic freeze_o,
    input logic bus_inhibit_o,
    input logic tx_zero_o,
    input logic rx_abort_o,
    input logic frame_block_o,
    input logic key_null_o
);
    // R3
    ill_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ill_addr_i |=> err_ill_o);

    // R4
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_tmo_o && !clr_tmo_i) |=> err_tmo_o);

    // R4
    ill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ill_o && !clr_ill_i) |=> err_ill_o);

    // R5
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && !unfreeze_i) |=> freeze_o);

    // R5
    freeze_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_o) |-> $past(freeze_pol_i));

    // R6
    degrade_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_addr_i && !freeze_pol_i && !bus_inhibit_o) |=> (bus_inhibit_o && !freeze_o));

    // R9
    degrade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_inhibit_o && !freeze_o && !cycle_start_i) |=> (bus_inhibit_o && !freeze_o));

    // R8
    key_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_block_o && key_slot_i) && !(key_null_o && !key_slot_i));

    // R7
    slot_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({(tx_zero_o || rx_abort_o), (frame_block_o || key_null_o), freeze_o}));

    // R10
    frozen_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && ill_addr_i && !unfreeze_i) |=> (freeze_o && !frame_block_o));
endmodule

bind bus_fail_supervisor bfs_checker i_chk (.*);

// File: tb/test_bus_fail_supervisor.sv
`timescale 1ns/1ps
module test_bus_fail_supervisor;
    localparam int TMO_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic acc_req_i, acc_done_i, ill_addr_i;
    logic [TMO_W-1:0] tmo_cfg_i;
    logic freeze_pol_i, clr_tmo_i, clr_ill_i, unfreeze_i;
    logic cycle_start_i, slot_start_i, key_slot_i, tx_active_i, rx_active_i;
    logic err_tmo_o, err_ill_o, freeze_o, bus_inhibit_o;
    logic tx_zero_o, rx_abort_o, frame_block_o, key_null_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bus_fail_supervisor #(.TMO_W(TMO_W)) i_bus_fail_supervisor (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic recover();
        @(negedge clk);
        cycle_start_i = 1'b1; unfreeze_i = 1'b1; clr_tmo_i = 1'b1; clr_ill_i = 1'b1;
        @(negedge clk);
        cycle_start_i = 1'b0; unfreeze_i = 1'b0; clr_tmo_i = 1'b0; clr_ill_i = 1'b0;
    endtask

    task automatic pulse_ill();
        @(negedge clk); ill_addr_i = 1'b1;
        @(negedge clk); ill_addr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 err_tmo", err_tmo_o, 1'b0);
        chk("R11 err_ill", err_ill_o, 1'b0);
        chk("R11 freeze", freeze_o, 1'b0);
        chk("R11 inhibit", bus_inhibit_o, 1'b0);
        chk("R11 frame_block", frame_block_o | key_null_o | tx_zero_o | rx_abort_o, 1'b0);
    endtask

    task automatic t_timeout();
        tmo_cfg_i = 8'd3;
        @(negedge clk); acc_req_i = 1'b1;
        @(posedge clk);
        @(negedge clk); acc_req_i = 1'b0;
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R1 before expiry", err_tmo_o, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 at expiry", err_tmo_o, 1'b1);
        chk("R6 inhibit after timeout", bus_inhibit_o, 1'b1);
        chk("R3 ill flag untouched", err_ill_o, 1'b0);
        recover();
        chk("R9 resume", bus_inhibit_o, 1'b0);
        chk("R4 clear", err_tmo_o, 1'b0);
    endtask

    task automatic t_success();
        tmo_cfg_i = 8'd3;
        @(negedge clk); acc_req_i = 1'b1;
        @(posedge clk);
        @(negedge clk); acc_req_i = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk); acc_done_i = 1'b1;
        @(posedge clk);
        @(negedge clk); acc_done_i = 1'b0;
        chk("R1 done in last cycle", err_tmo_o, 1'b0);
        cyc(12);
        chk("R1 counter stopped", err_tmo_o, 1'b0);
        chk("R1 no inhibit", bus_inhibit_o, 1'b0);
    endtask

    task automatic t_short(input logic [TMO_W-1:0] t);
        tmo_cfg_i = t;
        @(negedge clk); acc_req_i = 1'b1;
        @(posedge clk);
        @(negedge clk); acc_req_i = 1'b0; acc_done_i = 1'b1;
        @(posedge clk);
        @(negedge clk); acc_done_i = 1'b0;
        chk("R2 short timeout", err_tmo_o, 1'b1);
        recover();
    endtask

    task automatic t_degrade();
        freeze_pol_i = 1'b0; tx_active_i = 1'b1; rx_active_i = 1'b1; key_slot_i = 1'b0;
        pulse_ill();
        chk("R3 ill flag", err_ill_o, 1'b1);
        chk("R6 inhibit", bus_inhibit_o, 1'b1);
        chk("R6 no freeze", freeze_o, 1'b0);
        chk("R7 tx_zero", tx_zero_o, 1'b1);
        chk("R7 rx_abort", rx_abort_o, 1'b1);
        chk("R7 no block yet", frame_block_o, 1'b0);
        @(negedge clk); slot_start_i = 1'b1;
        @(negedge clk); slot_start_i = 1'b0;
        chk("R8 block", frame_block_o, 1'b1);
        chk("R8 tx_zero off", tx_zero_o, 1'b0);
        chk("R8 rx_abort off", rx_abort_o, 1'b0);
        key_slot_i = 1'b1; #1;
        chk("R8 key null", key_null_o, 1'b1);
        chk("R8 key not blocked", frame_block_o, 1'b0);
        key_slot_i = 1'b0;
        freeze_pol_i = 1'b1;
        pulse_ill();
        chk("R10 no freeze in degrade", freeze_o, 1'b0);
        chk("R10 still blocked", frame_block_o, 1'b1);
        freeze_pol_i = 1'b0;
        tmo_cfg_i = 8'd2;
        @(negedge clk); clr_tmo_i = 1'b1; acc_req_i = 1'b1;
        @(negedge clk); clr_tmo_i = 1'b0;
        cyc(12);
        acc_req_i = 1'b0;
        chk("R6 no watchdog while inhibited", err_tmo_o, 1'b0);
        @(negedge clk); cycle_start_i = 1'b1;
        @(negedge clk); cycle_start_i = 1'b0;
        chk("R9 inhibit off", bus_inhibit_o, 1'b0);
        chk("R9 outputs quiet", tx_zero_o | rx_abort_o | frame_block_o | key_null_o, 1'b0);
        tx_active_i = 1'b0; rx_active_i = 1'b0;
        recover();
    endtask

    task automatic t_freeze();
        freeze_pol_i = 1'b1;
        pulse_ill();
        chk("R5 freeze", freeze_o, 1'b1);
        chk("R5 inhibit", bus_inhibit_o, 1'b1);
        @(negedge clk); cycle_start_i = 1'b1;
        @(negedge clk); cycle_start_i = 1'b0;
        chk("R5 freeze across cycle start", freeze_o, 1'b1);
        freeze_pol_i = 1'b0;
        pulse_ill();
        chk("R10 frozen stays frozen", freeze_o, 1'b1);
        @(negedge clk); unfreeze_i = 1'b1;
        @(negedge clk); unfreeze_i = 1'b0;
        chk("R5 unfreeze", freeze_o, 1'b0);
        chk("R5 inhibit released", bus_inhibit_o, 1'b0);
        recover();
    endtask

    task automatic t_sticky();
        freeze_pol_i = 1'b1;
        pulse_ill();
        cyc(5);
        chk("R4 flag held", err_ill_o, 1'b1);
        @(negedge clk); ill_addr_i = 1'b1; clr_ill_i = 1'b1;
        @(negedge clk); ill_addr_i = 1'b0; clr_ill_i = 1'b0;
        chk("R4 set beats clear", err_ill_o, 1'b1);
        @(negedge clk); clr_ill_i = 1'b1;
        @(negedge clk); clr_ill_i = 1'b0;
        chk("R4 clear", err_ill_o, 1'b0);
        freeze_pol_i = 1'b0;
        recover();
    endtask

    initial begin
        rst_n = 1'b0;
        acc_req_i = 0; acc_done_i = 0; ill_addr_i = 0; tmo_cfg_i = '0;
        freeze_pol_i = 0; clr_tmo_i = 0; clr_ill_i = 0; unfreeze_i = 0;
        cycle_start_i = 0; slot_start_i = 0; key_slot_i = 0;
        tx_active_i = 0; rx_active_i = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_timeout();
        t_success();
        t_short(8'd1);
        t_short(8'd0);
        t_degrade();
        t_freeze();
        t_sticky();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule